// File: doc/BRIEF.md
# Output Latency Step Controller

This block holds the signed phase-offset word that a downstream phase-adjusting delay line uses to set the delay from input clock to output clock. One count of the word equals one period of the reference oscillator. Two asynchronous adjust inputs move the word up or down one count for each pulse. The word wraps around at its width and never saturates.

The word is the sum of two internal terms. The user term moves only with the adjust pulses. The buildout term absorbs the phase error of a new reference when the input clock is switched. A switch event arrives as a one-cycle strobe together with the measured phase error of the new input. When phase buildout is enabled, that error is added to the buildout term, so the output does not see the phase step. Holding both adjust inputs high disables buildout. A switch then clears the buildout term, and the output goes back to the user term, which keeps a fixed input-to-output phase.

Top module: `latency_step_ctrl`

## Requirements
- R1: Each low-to-high transition of `lat_up`, with `lat_down` low, adds exactly one to `offset`, whatever the width of the pulse.
- R2: Each low-to-high transition of `lat_down`, with `lat_up` low, subtracts exactly one from `offset`, whatever the width of the pulse.
- R3: `offset` is a 16-bit two's-complement value that wraps modulo 2^16 on both the step and the buildout additions. For example, 0x0000 minus one gives 0xFFFF, and 0x7FFF plus one gives 0x8000.
- R4: While `lat_up` and `lat_down` are both high, buildout is disabled. A `sw_stb` pulse then discards the accumulated buildout and ignores `sw_err`, so `offset` becomes the user term alone.
- R5: While buildout is enabled, a `sw_stb` pulse adds `sw_err` (two's complement) to `offset`, and the result is visible right after the first rising clock edge that samples the strobe.
- R6: A rising transition on one adjust input while the other is high causes no step. This includes both inputs rising together. Releasing either input causes no step either.
- R7: Reset (`rst_n` low) clears `offset` to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lat_up | input | 1 | Asynchronous latency-increase request, pulse or level |
| lat_down | input | 1 | Asynchronous latency-decrease request, pulse or level |
| sw_stb | input | 1 | One-cycle strobe marking an input clock switch, synchronous to clk |
| sw_err | input | 16 | Measured phase error of the new input, two's complement |
| offset | output | 16 | Offset word driven to the delay line, two's complement |

## Verification
The hardest state to reach is buildout disabled. Both adjust inputs have to sit high together, and they must get there without triggering a step on the way. The stimulus raises both inputs in the same cycle, so each rising edge is masked by the other level. It then applies a switch strobe, and it also re-pulses one input while the other stays high. The wrap is reached by stepping down past zero and by loading 0x7FFF into the buildout term through a switch error, so that two up steps carry the sum across the sign boundary.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;
endpackage

// File: rtl/lsc_sync_edge.sv
module lsc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = din;
                st_d.prev  = st_q.chain[0];
            end
        end else begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], din};
                st_d.prev  = st_q.chain[STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.prev;

    AST_ONE_EDGE_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R1
endmodule

// File: rtl/lsc_offset_core.sv
module lsc_offset_core
    import lsc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_lvl,
    input  logic         up_rise,
    input  logic         dn_lvl,
    input  logic         dn_rise,
    input  logic         sw_stb,
    input  logic [W-1:0] sw_err,
    output logic [W-1:0] offset_o
);
    typedef struct packed {
        logic [W-1:0] user;
        logic [W-1:0] pbo;
    } ofs_t;

    ofs_t st_d, st_q;
    adj_e act;
    logic bo_en;

    always_comb begin
        act = ADJ_NONE;
        if (up_rise && !dn_lvl)      act = ADJ_UP;
        else if (dn_rise && !up_lvl) act = ADJ_DOWN;
        bo_en = !(up_lvl && dn_lvl);

        st_d = st_q;
        case (act)
            ADJ_UP:   st_d.user = st_q.user + W'(1);
            ADJ_DOWN: st_d.user = st_q.user - W'(1);
            default:  st_d.user = st_q.user;
        endcase
        if (sw_stb) begin
            if (bo_en) st_d.pbo = st_q.pbo + sw_err;
            else       st_d.pbo = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign offset_o = st_q.user + st_q.pbo;

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rise && !dn_lvl) |=> st_q.user == $past(st_q.user) + W'(1)); // R1
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_rise && !up_lvl) |=> st_q.user == $past(st_q.user) - W'(1)); // R2
    AST_NO_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rise && !dn_lvl && st_q.user == {1'b0, {(W-1){1'b1}}})
        |=> st_q.user == {1'b1, {(W-1){1'b0}}}); // R3
    AST_FIXED_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stb && up_lvl && dn_lvl) |=> st_q.pbo == '0); // R4
    AST_BUILDOUT_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stb && !(up_lvl && dn_lvl)) |=> st_q.pbo == $past(st_q.pbo) + $past(sw_err)); // R5
    AST_MASKED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_rise && dn_lvl) || (dn_rise && up_lvl) || (!up_rise && !dn_rise))
        |=> $stable(st_q.user)); // R6
endmodule

// File: rtl/latency_step_ctrl.sv
module latency_step_ctrl #(
    parameter int OFS_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lat_up,
    input  logic             lat_down,
    input  logic             sw_stb,
    input  logic [OFS_W-1:0] sw_err,
    output logic [OFS_W-1:0] offset
);
    logic up_lvl, up_rise, dn_lvl, dn_rise;

    lsc_sync_edge #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .rst_n(rst_n), .din(lat_up),
        .level_o(up_lvl), .rise_o(up_rise)
    );

    lsc_sync_edge #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .rst_n(rst_n), .din(lat_down),
        .level_o(dn_lvl), .rise_o(dn_rise)
    );

    lsc_offset_core #(.W(OFS_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .up_lvl(up_lvl), .up_rise(up_rise),
        .dn_lvl(dn_lvl), .dn_rise(dn_rise),
        .sw_stb(sw_stb), .sw_err(sw_err),
        .offset_o(offset)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (offset == '0 || !rst_n)); // R7
endmodule

// File: tb/sim_latency_step_ctrl.sv
module sim_latency_step_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lat_up = 1'b0;
    logic        lat_down = 1'b0;
    logic        sw_stb = 1'b0;
    logic [15:0] sw_err = '0;
    logic [15:0] offset;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    latency_step_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lat_up(lat_up), .lat_down(lat_down),
        .sw_stb(sw_stb), .sw_err(sw_err), .offset(offset)
    );

    // op 0: up pulse (arg = width), op 1: down pulse, op 2: switch (arg = err)
    localparam logic [33:0] VEC [8] = '{
        {2'd0, 16'd1,      16'h0001},  // R1
        {2'd0, 16'd3,      16'h0002},  // R1 wide pulse
        {2'd1, 16'd1,      16'hFFFF + 16'h0002},
        {2'd2, 16'd100,    16'h0065},  // R5
        {2'd1, 16'd2,      16'h0064},  // R2 wide pulse
        {2'd2, 16'hFED4,   16'hFF38},  // R5 negative error
        {2'd0, 16'd1,      16'hFF39},  // R1
        {2'd2, 16'h0010,   16'hFF49}   // R5
    };

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (offset !== exp) begin
            errors++;
            $display("FAIL %s: offset=%h expected=%h", req, offset, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_up(input int w);
        @(negedge clk); lat_up = 1'b1;
        repeat (w) @(negedge clk);
        lat_up = 1'b0;
        settle();
    endtask

    task automatic pulse_down(input int w);
        @(negedge clk); lat_down = 1'b1;
        repeat (w) @(negedge clk);
        lat_down = 1'b0;
        settle();
    endtask

    // Checks the result one edge after the strobe is sampled (R5 timing)
    task automatic do_switch(input logic [15:0] err, input string req, input logic [15:0] exp);
        @(negedge clk); sw_stb = 1'b1; sw_err = err;
        @(posedge clk); #1;
        check(req, exp);
        @(negedge clk); sw_stb = 1'b0; sw_err = '0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: offset=%h expected=run completion", offset);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            case (VEC[i][33:32])
                2'd0: begin pulse_up(int'(VEC[i][31:16]));   check("R1", VEC[i][15:0]); end
                2'd1: begin pulse_down(int'(VEC[i][31:16])); check("R2", VEC[i][15:0]); end
                default: do_switch(VEC[i][31:16], "R5", VEC[i][15:0]);
            endcase
        end

        // Both rise together: no step, buildout disabled
        @(negedge clk); lat_up = 1'b1; lat_down = 1'b1;
        settle();
        check("R6", 16'hFF49);
        do_switch(16'h0500, "R4", 16'h0001);
        settle();
        check("R4", 16'h0001);
        // Re-pulse up while down stays high
        @(negedge clk); lat_up = 1'b0;
        settle();
        check("R6", 16'h0001);
        @(negedge clk); lat_up = 1'b1;
        settle();
        check("R6", 16'h0001);
        @(negedge clk); lat_up = 1'b0; lat_down = 1'b0;
        settle();
        check("R6", 16'h0001);

        // Wrap
        pulse_down(1);
        pulse_down(1);
        check("R3", 16'hFFFF);
        do_switch(16'h7FFF, "R5", 16'h7FFE);
        pulse_up(1);
        check("R3", 16'h7FFF);
        pulse_up(1);
        check("R3", 16'h8000);

        // Reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R7", 16'h0000);
        rst_n = 1'b1;
        pulse_up(2);
        check("R1", 16'h0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule